// File: doc/BRIEF.md
# Voltage ID Start-up Sequencer

This block sequences the reference code of a processor core regulator from power-up to normal operation. It stays idle until both supply power-on-reset indications are good. On the next rising edge of the enable input it captures a 2-bit boot selection, read as static levels on the two serial-interface pins, and maps it to a DAC code. It then turns on the output drivers and soft-starts the DAC code from zero up to that boot level, one step at a time.

Once the boot level is reached, power-good is raised. While the processor's power-OK input is high, each decoded command strobe loads a new target code, and the DAC code moves to it at the same fixed slew. When power-OK is withdrawn, the reference slews back to the captured boot level. When it is granted again, new commands are accepted. Dropping enable, or losing either power-on-reset indication, turns the drivers off, clears power-good and zeroes the DAC code at once.

One DAC step is 12.5 mV. The required slew of 1.875 mV/µs gives one step every 6.67 µs. `STEP_CYCLES` holds that interval in clock cycles; its default of 667 assumes a 100 MHz clock.

Top module: `vid_startup_seq`

## Requirements
- R1: After reset, `dac_code` is 0 and `pgood` and `drv_en` are 0. Until both `por_vcc_ok` and `por_vin_ok` are 1, an enable pulse starts nothing.
- R2: On a rising edge of `en`, once both POR inputs have been good for at least one cycle, the block captures {`svc`,`svd`} (`svc` is the MSB). It soft-starts to code 40, 60, 80 or 100 for selections 00, 01, 10 and 11 (default table). Pin changes after the capture have no effect.
- R3: During soft-start, `dac_code` rises from 0 in increments of exactly one and never skips a value. `drv_en` is 1 from the start of soft-start.
- R4: Every change of `dac_code`, up or down, lies exactly `STEP_CYCLES` clock cycles after the previous change in the same ramp.
- R5: `pgood` stays 0 until `dac_code` equals the boot level at the end of soft-start. It rises one cycle after that.
- R6: While `pwr_ok` is 0, a pulse on `cmd_valid` does not change the target, and `dac_code` stays at the boot level.
- R7: While `pwr_ok` is 1 after soft-start, a `cmd_valid` pulse makes `cmd_code` the new target. `dac_code` slews up or down to it, and `pgood` stays 1 throughout.
- R8: When `pwr_ok` falls after soft-start, `dac_code` slews back to the boot level. After `pwr_ok` rises again, commands are accepted once more.
- R9: When `en` is 0 at a clock edge, `drv_en`, `pgood` and `dac_code` are all 0 after that edge. A later rising edge of `en` captures the pins afresh.
- R10: When either POR input drops, `drv_en`, `pgood` and `dac_code` are 0 after the next clock edge.
- R11: If `en` is already high when power-on reset completes, or stays high across a POR loss, no start-up occurs. Only a fresh rising edge of `en` starts the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_vcc_ok | input | 1 | Bias supply power-on-reset good |
| por_vin_ok | input | 1 | Input supply power-on-reset good |
| en | input | 1 | Regulator enable; rising edge captures the boot selection |
| pwr_ok | input | 1 | Processor power-OK; gates command acceptance |
| svc | input | 1 | Serial clock pin, read as boot-select MSB |
| svd | input | 1 | Serial data pin, read as boot-select LSB |
| cmd_valid | input | 1 | One-cycle strobe for a decoded new voltage code |
| cmd_code | input | DAC_W | Decoded new voltage code |
| dac_code | output | DAC_W | Reference DAC code |
| pgood | output | 1 | Power-good |
| drv_en | output | 1 | Output driver enable (0 = drivers tri-stated) |

## Verification
The bench fires enable pulses before POR completes, and holds enable high across POR completion and across a POR loss. A design that treats the enable level as the trigger, instead of its rising edge, would start the regulator unbidden in these cases. During every soft-start the bench flips the boot pins right after capture, checks each DAC change for a single step and for an exact spacing, and flags any early power-good. A skipped step, a wrong slew interval, a live pin connection or a premature power-good would each show up there. Commands are sent with power-OK low, both during a fallback and after it. A design that lets them through, or that fails to fall back to the boot level, ends at the wrong code. Finally, a re-enable with different pins catches a block that keeps its old boot selection.

// File: rtl/vid_pkg.sv
package vid_pkg;
  typedef enum logic [1:0] {
    ST_WAIT_POR = 2'd0,
    ST_IDLE     = 2'd1,
    ST_SOFT     = 2'd2,
    ST_RUN      = 2'd3
  } seq_state_t;
endpackage

// File: rtl/boot_capture.sv
module boot_capture #(
  parameter int DAC_W = 8,
  parameter logic [4*DAC_W-1:0] BOOT_TABLE = {8'd100, 8'd80, 8'd60, 8'd40}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [1:0]       pins,
  output logic [DAC_W-1:0] boot_val
);
  localparam int N_SEL = 4;

  logic [DAC_W-1:0] lut [N_SEL];

  for (genvar i = 0; i < N_SEL; i++) begin : g_lut
    assign lut[i] = BOOT_TABLE[i*DAC_W +: DAC_W];
  end

  always_ff @(posedge clk) begin
    if (rst)          boot_val <= lut[0];
    else if (capture) boot_val <= lut[pins];
  end

  // R2
  boot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(boot_val));
endmodule

// File: rtl/slew_ramp.sv
module slew_ramp #(
  parameter int DAC_W       = 8,
  parameter int STEP_CYCLES = 667
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [DAC_W-1:0] target,
  output logic [DAC_W-1:0] code
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      code <= '0;
      cnt  <= '0;
    end else if (code == target) begin
      cnt <= '0;
    end else if (cnt == CNT_LAST) begin
      cnt  <= '0;
      code <= (code < target) ? code + 1'b1 : code - 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ($stable(code) || code == $past(code) + 1'b1 || code == $past(code) - 1'b1));

  if (STEP_CYCLES > 1) begin : g_gap_chk
    // R4
    step_gap_chk: assert property (@(posedge clk) disable iff (rst)
      (!clr && !$stable(code)) |=> ($stable(code) || clr));
  end
endmodule

// File: rtl/vid_startup_seq.sv
module vid_startup_seq
  import vid_pkg::*;
#(
  parameter int DAC_W       = 8,
  parameter int STEP_CYCLES = 667,
  parameter logic [4*DAC_W-1:0] BOOT_TABLE = {8'd100, 8'd80, 8'd60, 8'd40}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             por_vcc_ok,
  input  logic             por_vin_ok,
  input  logic             en,
  input  logic             pwr_ok,
  input  logic             svc,
  input  logic             svd,
  input  logic             cmd_valid,
  input  logic [DAC_W-1:0] cmd_code,
  output logic [DAC_W-1:0] dac_code,
  output logic             pgood,
  output logic             drv_en
);
  seq_state_t       state;
  logic [DAC_W-1:0] target;
  logic [DAC_W-1:0] boot_val;
  logic             en_q;
  logic             por_all;
  logic             en_rise;
  logic             capture;
  logic             ramp_clr;

  assign por_all  = por_vcc_ok & por_vin_ok;
  assign en_rise  = en & ~en_q;
  assign capture  = (state == ST_IDLE) & por_all & en_rise;
  assign ramp_clr = ~por_all | ~en | (state == ST_WAIT_POR) | (state == ST_IDLE);

  boot_capture #(.DAC_W(DAC_W), .BOOT_TABLE(BOOT_TABLE)) u_boot (
    .clk      (clk),
    .rst      (rst),
    .capture  (capture),
    .pins     ({svc, svd}),
    .boot_val (boot_val)
  );

  slew_ramp #(.DAC_W(DAC_W), .STEP_CYCLES(STEP_CYCLES)) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .clr    (ramp_clr),
    .target (target),
    .code   (dac_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_WAIT_POR;
      target <= '0;
      pgood  <= 1'b0;
      drv_en <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      en_q <= en;
      if (!por_all) begin
        state  <= ST_WAIT_POR;
        target <= '0;
        pgood  <= 1'b0;
        drv_en <= 1'b0;
      end else begin
        case (state)
          ST_WAIT_POR: state <= ST_IDLE;
          ST_IDLE: begin
            target <= '0;
            if (en_rise) begin
              state  <= ST_SOFT;
              drv_en <= 1'b1;
            end
          end
          ST_SOFT: begin
            if (!en) begin
              state  <= ST_IDLE;
              drv_en <= 1'b0;
              pgood  <= 1'b0;
              target <= '0;
            end else begin
              target <= boot_val;
              if (target == boot_val && dac_code == boot_val) begin
                state <= ST_RUN;
                pgood <= 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (!en) begin
              state  <= ST_IDLE;
              drv_en <= 1'b0;
              pgood  <= 1'b0;
              target <= '0;
            end else if (!pwr_ok) begin
              target <= boot_val;
            end else if (cmd_valid) begin
              target <= cmd_code;
            end
          end
          default: state <= ST_WAIT_POR;
        endcase
      end
    end
  end

  // R9
  en_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!drv_en && !pgood && dac_code == '0));

  // R10
  por_off_chk: assert property (@(posedge clk) disable iff (rst)
    !por_all |=> (!drv_en && !pgood && dac_code == '0));

  // R5
  pgood_level_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> (dac_code == boot_val));

  // R6
  fallback_target_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RUN && por_all && en && !pwr_ok) |=> (target == boot_val));

  // R3
  drv_with_pgood_chk: assert property (@(posedge clk) disable iff (rst)
    pgood |-> drv_en);
endmodule

// File: tb/sim_vid_startup_seq.sv
module sim_vid_startup_seq;
  localparam int W = 8;
  localparam int S = 5;

  logic         clk = 1'b0;
  logic         rst, por_vcc_ok, por_vin_ok, en, pwr_ok, svc, svd, cmd_valid;
  logic [W-1:0] cmd_code;
  logic [W-1:0] dac_code;
  logic         pgood, drv_en;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 0;

  always #5 clk = ~clk;

  vid_startup_seq #(.DAC_W(W), .STEP_CYCLES(S)) u0 (
    .clk(clk), .rst(rst), .por_vcc_ok(por_vcc_ok), .por_vin_ok(por_vin_ok),
    .en(en), .pwr_ok(pwr_ok), .svc(svc), .svd(svd), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .dac_code(dac_code), .pgood(pgood), .drv_en(drv_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_dac(input int exp, input int maxc, output bit hit, output bit pg_drop);
    hit = 0; pg_drop = 0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (!pgood) pg_drop = 1;
      if (int'(dac_code) == exp) begin hit = 1; break; end
    end
  endtask

  task automatic send_cmd(input int code);
    @(negedge clk); cmd_code = W'(code); cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(dac_code == 0, "R1 dac after reset", int'(dac_code), 0);
    chk(pgood == 0, "R1 pgood after reset", pgood, 0);
    chk(drv_en == 0, "R1 drv_en after reset", drv_en, 0);
  endtask

  task automatic t_no_por();
    por_vcc_ok = 1'b1; {svc, svd} = 2'b11;
    step(2); en = 1'b1; step(40);
    chk(drv_en == 0 && dac_code == 0, "R1 enable before POR", int'(dac_code), 0);
    en = 1'b0; step(2);
  endtask

  task automatic t_en_held();
    en = 1'b1; step(5); por_vin_ok = 1'b1; step(30);
    chk(drv_en == 0, "R11 en held across POR drv_en", drv_en, 0);
    chk(dac_code == 0, "R11 en held across POR dac", int'(dac_code), 0);
    en = 1'b0; step(2);
  endtask

  task automatic t_soft(input logic [1:0] sel, input int exp);
    int prev, last, bad_step, bad_gap, early_pg;
    @(negedge clk); {svc, svd} = sel; en = 1'b0;
    @(negedge clk); en = 1'b1;
    @(negedge clk); {svc, svd} = ~sel;
    chk(drv_en == 1, "R3 drv_en at soft-start", drv_en, 1);
    prev = int'(dac_code); last = -1; bad_step = 0; bad_gap = 0; early_pg = 0;
    for (int i = 0; i < exp*S + 40; i++) begin
      @(negedge clk);
      if (int'(dac_code) != prev) begin
        if (int'(dac_code) != prev + 1) bad_step++;
        if (last >= 0 && i - last != S) bad_gap++;
        last = i; prev = int'(dac_code);
      end
      if (pgood && int'(dac_code) != exp) early_pg++;
      if (pgood) break;
    end
    chk(bad_step == 0, "R3 single steps", bad_step, 0);
    chk(bad_gap == 0, "R4 step spacing", bad_gap, 0);
    chk(early_pg == 0, "R5 early pgood", early_pg, 0);
    chk(pgood == 1, "R5 pgood at target", pgood, 1);
    chk(int'(dac_code) == exp, "R2 boot level", int'(dac_code), exp);
  endtask

  task automatic t_cmd_ignored();
    pwr_ok = 1'b0;
    send_cmd(20); step(40);
    chk(dac_code == 80, "R6 command with pwr_ok low", int'(dac_code), 80);
  endtask

  task automatic t_cmd();
    bit hit, drop;
    pwr_ok = 1'b1; step(2);
    send_cmd(95); wait_dac(95, 20*S + 20, hit, drop);
    chk(hit, "R7 slew up to command", int'(dac_code), 95);
    chk(!drop, "R7 pgood held on up slew", 0, 1);
    send_cmd(30); wait_dac(30, 70*S + 20, hit, drop);
    chk(hit, "R7 slew down to command", int'(dac_code), 30);
    chk(!drop, "R7 pgood held on down slew", 0, 1);
  endtask

  task automatic t_pwrok_drop();
    bit hit, drop;
    @(negedge clk); pwr_ok = 1'b0;
    send_cmd(10);
    wait_dac(80, 55*S + 20, hit, drop);
    chk(hit, "R8 return to boot level", int'(dac_code), 80);
    step(3*S);
    chk(dac_code == 80, "R8 held at boot level", int'(dac_code), 80);
    pwr_ok = 1'b1; step(2);
    send_cmd(50); wait_dac(50, 35*S + 20, hit, drop);
    chk(hit, "R8 command after pwr_ok returns", int'(dac_code), 50);
  endtask

  task automatic t_en_fall();
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    chk(drv_en == 0, "R9 drv_en after enable low", drv_en, 0);
    chk(pgood == 0, "R9 pgood after enable low", pgood, 0);
    chk(dac_code == 0, "R9 dac after enable low", int'(dac_code), 0);
  endtask

  task automatic t_por_loss();
    @(negedge clk); por_vin_ok = 1'b0;
    @(negedge clk);
    chk(drv_en == 0 && pgood == 0, "R10 off after POR loss", {drv_en, pgood}, 0);
    chk(dac_code == 0, "R10 dac after POR loss", int'(dac_code), 0);
    step(10); por_vin_ok = 1'b1; step(30);
    chk(drv_en == 0 && dac_code == 0, "R11 no restart without new enable edge", drv_en, 0);
    en = 1'b0; step(2);
  endtask

  initial begin
    rst = 1'b1; por_vcc_ok = 1'b0; por_vin_ok = 1'b0; en = 1'b0; pwr_ok = 1'b0;
    svc = 1'b0; svd = 1'b0; cmd_valid = 1'b0; cmd_code = '0;
    step(3); rst = 1'b0; step(1);
    t_reset();
    t_no_por();
    t_en_held();
    t_soft(2'b10, 80);
    t_cmd_ignored();
    t_cmd();
    t_pwrok_drop();
    t_en_fall();
    t_soft(2'b00, 40);   // R9 recapture with new pins
    t_por_loss();
    t_soft(2'b11, 100);
    t_soft(2'b01, 60);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule